// File: doc/BRIEF.md
# Segment Drive Data Path for a Passive LCD Column Driver

This block is the digital core of a 120-column segment driver for a passive liquid crystal panel. A line of display data arrives on a shift strobe. A mode pin picks one of two input forms: four bits per strobe on a 4-bit bus, or one bit per strobe on bit 0 of that bus. A write pointer places each arriving bit into a data latch. When a line pulse falls, the captured line moves into a line latch and the pointer starts over for the next line.

Each segment output is a 2-bit code that names one of four supply levels. The code comes from the segment's line-latch bit and a frame-inversion input. A drive-enable input blanks the panel. While it is low, every segment is forced to the ground level and the line latch is held clear. Capture into the data latch goes on during blanking. After the enable returns, the segments show the non-select level until the next line pulse, and from that pulse on they show data.

The shift strobe and the line pulse are sampled by the block clock. A falling edge is a high sample followed by a low sample. Reset is synchronous and active high.

Top module: `seg_lcd_core`

## Requirements
- R1: Reset clears the data latch, the line latch and the write pointer. Until the first line-pulse falling edge after reset, every segment shows the non-select level: code 10 when frame_inv is 1, code 11 when frame_inv is 0.
- R2: With par_mode high, each shift falling edge stores din[3], din[2], din[1], din[0] into segments p, p+1, p+2, p+3, where p is the write pointer. The pointer then advances by 4.
- R3: With par_mode low, each shift falling edge stores din[0] into segment p and advances the pointer by 1. din[3:1] have no effect.
- R4: Capture happens only on a high-to-low transition of shift_clk. A strobe held low for several clock cycles stores exactly one group.
- R5: A falling edge of line_pulse copies the data latch into the line latch and returns the write pointer to segment 0.
- R6: Once all 120 segments of a line are filled, further shift edges leave the data latch unchanged until the next line-pulse falling edge.
- R7: Segment k drives seg_lvl[2k+1:2k]. The codes are 00 = ground, 01 = V0, 10 = V2, 11 = V3. With frame_inv=1, a latched 1 gives V0 and a latched 0 gives V2. With frame_inv=0, a latched 1 gives ground and a latched 0 gives V3.
- R8: While drive_en is low, every segment code is 00 and the line latch is cleared. Shift edges still fill the data latch.
- R9: After drive_en returns high, segments show the non-select level of R1 until the next line-pulse falling edge. After that edge they show the data latch contents under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples every control input |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | input | 1 | Data shift strobe; its falling edge captures input data |
| line_pulse | input | 1 | Line strobe; its falling edge moves the line to the output latch |
| par_mode | input | 1 | 1 = four bits per strobe, 0 = one bit per strobe on din[0] |
| din | input | 4 | Display data input |
| frame_inv | input | 1 | Frame inversion control for the drive waveform |
| drive_en | input | 1 | Low blanks all segments to ground and clears the line latch |
| seg_lvl | output | 240 | Level code per segment, two bits each, segment 0 in the low bits |

## Verification
The bench fills lines with random data in both modes. In serial mode it puts random noise on din[3:1], so a design that also sampled those bits would corrupt segments. It shifts past the end of a full line: a pointer that wraps or does not saturate would overwrite the first segments. It holds the strobe low for several cycles: a level-sensitive capture would store repeated groups. It toggles frame inversion without a new line, which exposes a swapped truth table. It also blanks the drive in the middle of a line. If capture were dropped while blanked, the line would come out short. If the release went straight to the old line, the segments would show stale or live data before the next line pulse instead of the non-select level.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;

    typedef enum logic [1:0] {
        LVL_GND = 2'b00,
        LVL_V0  = 2'b01,
        LVL_V2  = 2'b10,
        LVL_V3  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic shift;
        logic latch;
    } strobe_t;

    function automatic lvl_e idle_level(input logic fr);
        return fr ? LVL_V2 : LVL_V3;
    endfunction

    function automatic lvl_e data_level(input logic bit_on, input logic fr);
        if (fr) return bit_on ? LVL_V0 : LVL_V2;
        return bit_on ? LVL_GND : LVL_V3;
    endfunction

endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig;
    end

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign fall[i] = prev_q[i] & ~sig[i];
    end
endmodule

// File: rtl/seg_capture.sv
module seg_capture
    import seg_lcd_pkg::*;
#(
    parameter int NUM_SEG = 120,
    parameter int BUS_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  strobe_t            stb,
    input  logic               par_mode,
    input  logic [BUS_W-1:0]   din,
    output logic [NUM_SEG-1:0] data_q
);
    localparam int PTR_W = $clog2(NUM_SEG + 1);
    localparam int SEL_W = (BUS_W > 1) ? $clog2(BUS_W) : 1;
    localparam logic [PTR_W:0] FULL_W = (PTR_W+1)'(NUM_SEG);
    localparam logic [PTR_W:0] STEP_P = (PTR_W+1)'(BUS_W);

    logic [PTR_W-1:0]   ptr_q;
    logic [NUM_SEG-1:0] data_d;
    logic [PTR_W:0]     ptr_sum;
    logic [PTR_W-1:0]   ptr_d;
    logic               room;
    logic               take;

    assign room = (ptr_q < PTR_W'(NUM_SEG));
    assign take = stb.shift & ~stb.latch & room;

    always_comb begin
        data_d = data_q;
        for (int k = 0; k < NUM_SEG; k++) begin
            int off;
            off = k - int'(ptr_q);
            if (par_mode) begin
                if (off >= 0 && off < BUS_W)
                    data_d[k] = din[SEL_W'(BUS_W - 1 - off)];
            end else if (off == 0) begin
                data_d[k] = din[0];
            end
        end
    end

    always_comb begin
        ptr_sum = {1'b0, ptr_q} + (par_mode ? STEP_P : (PTR_W+1)'(1));
        ptr_d   = (ptr_sum > FULL_W) ? PTR_W'(NUM_SEG) : ptr_sum[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ptr_q  <= '0;
        end else if (stb.latch) begin
            ptr_q  <= '0;
        end else if (take) begin
            data_q <= data_d;
            ptr_q  <= ptr_d;
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_W'(NUM_SEG)); // R6
    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        stb.latch |=> ptr_q == '0); // R5
    AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stb.shift && !stb.latch && ptr_q == PTR_W'(NUM_SEG)) |=> $stable(data_q)); // R6
    AST_SERIAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (stb.shift && !stb.latch && !par_mode && ptr_q < PTR_W'(NUM_SEG))
        |=> ptr_q == $past(ptr_q) + PTR_W'(1)); // R3
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
    import seg_lcd_pkg::*;
#(
    parameter int NUM_SEG = 120
) (
    input  logic                 clk,
    input  logic                 rst,
    input  strobe_t              stb,
    input  logic                 drive_en,
    input  logic                 frame_inv,
    input  logic [NUM_SEG-1:0]   data_in,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    logic [NUM_SEG-1:0] line_q;
    logic               hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            hold_q <= 1'b1;
        end else if (!drive_en) begin
            line_q <= '0;
            hold_q <= 1'b1;
        end else if (stb.latch) begin
            line_q <= data_in;
            hold_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_lvl
        lvl_e lvl;
        always_comb begin
            if (!drive_en)   lvl = LVL_GND;
            else if (hold_q) lvl = idle_level(frame_inv);
            else             lvl = data_level(line_q[k], frame_inv);
        end
        assign seg_lvl[2*k +: 2] = lvl;
    end

    AST_RESET_NONSEL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> hold_q); // R1
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !drive_en |=> (line_q == '0 && hold_q)); // R8
    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> hold_q); // R9
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        (drive_en && stb.latch) |=> line_q == $past(data_in)); // R5
endmodule

// File: rtl/seg_lcd_core.sv
module seg_lcd_core
    import seg_lcd_pkg::*;
#(
    parameter int NUM_SEG = 120,
    parameter int BUS_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_clk,
    input  logic                 line_pulse,
    input  logic                 par_mode,
    input  logic [BUS_W-1:0]     din,
    input  logic                 frame_inv,
    input  logic                 drive_en,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    logic [1:0]         fall;
    strobe_t            stb;
    logic [NUM_SEG-1:0] data_q;

    seg_fall_det #(.N(2)) i_fall (
        .clk  (clk),
        .rst  (rst),
        .sig  ({shift_clk, line_pulse}),
        .fall (fall)
    );

    assign stb.shift = fall[1];
    assign stb.latch = fall[0];

    seg_capture #(.NUM_SEG(NUM_SEG), .BUS_W(BUS_W)) i_cap (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .par_mode (par_mode),
        .din      (din),
        .data_q   (data_q)
    );

    seg_out_stage #(.NUM_SEG(NUM_SEG)) i_out (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb),
        .drive_en  (drive_en),
        .frame_inv (frame_inv),
        .data_in   (data_q),
        .seg_lvl   (seg_lvl)
    );

    AST_OFF_GROUND: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> seg_lvl == '0); // R8
endmodule

// File: tb/test_seg_lcd_core.sv
module test_seg_lcd_core;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 120;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            shift_clk = 1'b1;
    logic            line_pulse = 1'b1;
    logic            par_mode = 1'b1;
    logic [3:0]      din = '0;
    logic            frame_inv = 1'b1;
    logic            drive_en = 1'b1;
    logic [2*NSEG-1:0] seg_lvl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NSEG-1:0] m_data, m_line;
    int              m_ptr;
    bit              m_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_lcd_core i_seg_lcd_core (
        .clk(clk), .rst(rst), .shift_clk(shift_clk), .line_pulse(line_pulse),
        .par_mode(par_mode), .din(din), .frame_inv(frame_inv),
        .drive_en(drive_en), .seg_lvl(seg_lvl)
    );

    function automatic logic [1:0] exp_code(input logic b, input logic fr,
                                            input logic en, input bit hold);
        if (!en)  return 2'b00;
        if (hold) return fr ? 2'b10 : 2'b11;
        if (fr)   return b ? 2'b01 : 2'b10;
        return b ? 2'b00 : 2'b11;
    endfunction

    function automatic logic [2*NSEG-1:0] exp_vec();
        logic [2*NSEG-1:0] v;
        for (int k = 0; k < NSEG; k++)
            v[2*k +: 2] = exp_code(m_line[k], frame_inv, drive_en, m_hold);
        return v;
    endfunction

    task automatic check_out(input string req);
        logic [2*NSEG-1:0] e;
        e = exp_vec();
        n_run++;
        if (seg_lvl !== e) begin
            n_fail++;
            $display("FAIL %s: seg_lvl=%h expected=%h", req, seg_lvl, e);
        end
    endtask

    task automatic shift(input logic [3:0] d, input int low_cycles);
        @(negedge clk);
        din = d;
        shift_clk = 1'b0;
        repeat (low_cycles) @(negedge clk);
        shift_clk = 1'b1;
        if (m_ptr < NSEG) begin
            if (par_mode) begin
                for (int i = 0; i < 4; i++)
                    if (m_ptr + i < NSEG) m_data[m_ptr + i] = d[3 - i];
                m_ptr = (m_ptr + 4 > NSEG) ? NSEG : m_ptr + 4;
            end else begin
                m_data[m_ptr] = d[0];
                m_ptr++;
            end
        end
    endtask

    task automatic latch();
        @(negedge clk);
        line_pulse = 1'b0;
        @(negedge clk);
        line_pulse = 1'b1;
        m_ptr = 0;
        if (drive_en) begin
            m_line = m_data;
            m_hold = 1'b0;
        end
    endtask

    task automatic set_enable(input logic en);
        @(negedge clk);
        drive_en = en;
        if (!en) begin
            m_line = '0;
            m_hold = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic fill_random(input int count);
        for (int i = 0; i < count; i++)
            shift(4'($urandom), 1);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_0A11);
        m_data = '0; m_line = '0; m_ptr = 0; m_hold = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out("R1 reset non-select fr=1");
        frame_inv = 1'b0; #1;
        check_out("R1 reset non-select fr=0");
        frame_inv = 1'b1;

        par_mode = 1'b1;
        shift(4'b1000, 1); shift(4'b0110, 1);
        fill_random(28);
        latch();
        check_out("R2 R5 parallel nibble order");

        par_mode = 1'b0;
        for (int i = 0; i < NSEG; i++) shift({3'($urandom), (i % 3) == 0}, 1);
        latch();
        check_out("R3 serial din0 only");

        par_mode = 1'b1;
        fill_random(30);
        shift(4'hF, 1); shift(4'h5, 1);
        latch();
        check_out("R6 overflow shifts ignored");

        par_mode = 1'b0;
        shift(4'h1, 4); shift(4'h0, 3); shift(4'h1, 1);
        for (int i = 3; i < NSEG; i++) shift(4'h0, 1);
        latch();
        check_out("R4 long low strobe captures once");

        for (int f = 0; f < 2; f++) begin
            frame_inv = logic'(f); #1;
            check_out("R7 truth table frame_inv");
        end

        par_mode = 1'b1;
        fill_random(10);
        set_enable(1'b0);
        check_out("R8 blanked outputs ground");
        fill_random(20);
        check_out("R8 ground while capturing");
        set_enable(1'b1);
        check_out("R9 non-select after release");
        frame_inv = ~frame_inv; #1;
        check_out("R9 non-select follows frame_inv");
        latch();
        check_out("R8 R9 data kept through blanking");

        for (int n = 0; n < 24; n++) begin
            int extra;
            par_mode = logic'($urandom_range(0, 1));
            frame_inv = logic'($urandom_range(0, 1));
            extra = $urandom_range(0, 3);
            if (par_mode) fill_random(30 + extra);
            else fill_random(NSEG + extra);
            if ($urandom_range(0, 5) == 0) begin
                set_enable(1'b0);
                check_out("R8 random blank");
                set_enable(1'b1);
                check_out("R9 random release");
            end
            latch();
            check_out(par_mode ? "R2 R7 random parallel line" : "R3 R7 random serial line");
            frame_inv = ~frame_inv; #1;
            check_out("R7 random frame flip");
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_data = '0; m_line = '0; m_ptr = 0; m_hold = 1'b1;
        @(negedge clk);
        check_out("R1 reset after activity");
        latch();
        check_out("R1 R5 first line after reset is cleared data");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule